// File: doc/BRIEF.md
# Run-Time Selectable PRBS Source with Error Insertion

This block produces a pseudo-random test pattern for a bit error ratio tester. A linear feedback shift register with a run-time selectable order, from 3 to 31, is advanced a full word of steps per clock. The result leaves the block as a parallel word, and a valid flag marks each new word. The first bit in time is carried in the most significant position.

The stream can be corrupted on purpose in two ways. A command strobe flips exactly one bit. A periodic mode flips one bit out of every N, with N programmable in bits, and the count runs straight across word boundaries. A polarity control complements the whole outgoing stream. A serializer downstream consumes the words; the host registers that drive the controls sit outside this block.

Top module: `prbs_pattern_src`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and on the first clock after it, `data_valid` is 0 and `data_out` is all zeros.
- R2: For an effective order N, bit n of the stream equals the XOR of bits n-k, for every exponent k of that order's polynomial other than the constant term. Bits before the first word after a reseed count as ones. Within a word, bit 31 is earliest in time. The polynomials are: 3:{3,2} 4:{4,3} 5:{5,3} 6:{6,5} 7:{7,6} 8:{8,6,5,4} 9:{9,5} 10:{10,7} 11:{11,9} 12:{12,6,4,1} 13:{13,4,3,1} 14:{14,5,3,1} 15:{15,14} 16:{16,15,13,4} 17:{17,14} 18:{18,11} 19:{19,6,2,1} 20:{20,17} 21:{21,19} 22:{22,21} 23:{23,18} 24:{24,23,22,17} 25:{25,22} 26:{26,6,2,1} 27:{27,5,2,1} 28:{28,25} 29:{29,27} 30:{30,6,4,1} 31:{31,28}.
- R3: When the effective order differs from the order in use (after reset the order in use is 31), that clock produces no word. `data_valid` goes to 0 for one cycle, `data_out` holds, and the register reseeds to all ones. In every cycle where the order is unchanged, `data_valid` is 1.
- R4: An `order_sel` value below 3 is treated as 3. Changing between such values and 3 does not reseed.
- R5: A rising edge on `err_single` flips bit 31 of the next word produced. Holding the strobe high produces no further errors.
- R6: A strobe edge that arrives in a reseed cycle is kept and applied to the first word after it.
- R7: With `err_periodic_en` high and spacing S > 0, every S-th stream bit is flipped. The count runs across word boundaries. The first flip falls on the S-th bit after the counter was cleared, and the counter only advances on words that are produced.
- R8: A spacing of 0 inserts no periodic errors. While `err_periodic_en` is low, or the spacing is 0, the counter is cleared.
- R9: A bit that is selected by both the single and the periodic mechanism is flipped once, not twice.
- R10: With `invert_en` high, every bit of each produced word is complemented after error insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| order_sel | input | 5 | Requested sequence order (3..31; lower values act as 3) |
| invert_en | input | 1 | Complement output polarity |
| err_single | input | 1 | Single-error command, edge sensitive |
| err_periodic_en | input | 1 | Enable evenly spaced errors |
| err_spacing | input | SPACE_W | Distance between periodic errors, in bits |
| data_out | output | WORD_W | Pattern word, MSB earliest |
| data_valid | output | 1 | A new word was produced this cycle |

## Verification
On every cycle the assertions check these properties:
- the shift register never reaches the all-zero state;
- a reseed cycle yields exactly one invalid output cycle;
- the periodic counter stays below the programmed spacing;
- the counter clears when the mode is off.

Three things can only be shown by comparing the bench's behavioural recurrence model against the output words:
- the exact bit sequence for each order;
- the position of each injected error, including spacings that straddle words and strobes that land in a reseed cycle;
- the single flip on coincident errors, and the polarity inversion.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;

   localparam int PRBS_MIN_ORD = 3;
   localparam int PRBS_MAX_ORD = 31;
   localparam int PRBS_ORD_W   = 5;

   typedef logic [PRBS_MAX_ORD-1:0] prbs_state_t;

   function automatic prbs_state_t exp_bit(input int e);
      return prbs_state_t'(1) << (e - 1);
   endfunction

   function automatic prbs_state_t taps2(input int a, input int b);
      return exp_bit(a) | exp_bit(b);
   endfunction

   function automatic prbs_state_t taps4(input int a, input int b, input int c, input int d);
      return exp_bit(a) | exp_bit(b) | exp_bit(c) | exp_bit(d);
   endfunction

   // bit k-1 set means state bit k-1 (the bit k steps back) feeds the XOR
   function automatic prbs_state_t prbs_tap_mask(input logic [PRBS_ORD_W-1:0] ord);
      case (ord)
         5'd3:    return taps2(3, 2);
         5'd4:    return taps2(4, 3);
         5'd5:    return taps2(5, 3);
         5'd6:    return taps2(6, 5);
         5'd7:    return taps2(7, 6);
         5'd8:    return taps4(8, 6, 5, 4);
         5'd9:    return taps2(9, 5);
         5'd10:   return taps2(10, 7);
         5'd11:   return taps2(11, 9);
         5'd12:   return taps4(12, 6, 4, 1);
         5'd13:   return taps4(13, 4, 3, 1);
         5'd14:   return taps4(14, 5, 3, 1);
         5'd15:   return taps2(15, 14);
         5'd16:   return taps4(16, 15, 13, 4);
         5'd17:   return taps2(17, 14);
         5'd18:   return taps2(18, 11);
         5'd19:   return taps4(19, 6, 2, 1);
         5'd20:   return taps2(20, 17);
         5'd21:   return taps2(21, 19);
         5'd22:   return taps2(22, 21);
         5'd23:   return taps2(23, 18);
         5'd24:   return taps4(24, 23, 22, 17);
         5'd25:   return taps2(25, 22);
         5'd26:   return taps4(26, 6, 2, 1);
         5'd27:   return taps4(27, 5, 2, 1);
         5'd28:   return taps2(28, 25);
         5'd29:   return taps2(29, 27);
         5'd30:   return taps4(30, 6, 4, 1);
         default: return taps2(31, 28);
      endcase
   endfunction

endpackage

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core
   import prbs_gen_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PRBS_ORD_W-1:0] ord_eff,
   output logic [WORD_W-1:0]     word,
   output logic                  adv,
   output prbs_state_t           state
);

   localparam prbs_state_t SEED = '1;

   prbs_state_t             st_q;
   prbs_state_t             st_nx;
   logic [PRBS_ORD_W-1:0]   ord_q;
   prbs_state_t             mask;

   assign mask  = prbs_tap_mask(ord_q);
   assign adv   = (ord_eff == ord_q);
   assign state = st_q;

   always_comb begin
      prbs_state_t s;
      logic        fb;
      s    = st_q;
      word = '0;
      for (int i = 0; i < WORD_W; i++) begin
         fb               = ^(s & mask);
         s                = {s[PRBS_MAX_ORD-2:0], fb};
         word[WORD_W-1-i] = fb;
      end
      st_nx = s;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= SEED;
         ord_q <= PRBS_ORD_W'(PRBS_MAX_ORD);
      end else if (!adv) begin
         st_q  <= SEED;
         ord_q <= ord_eff;
      end else begin
         st_q  <= st_nx;
      end
   end

endmodule

// File: rtl/prbs_err_inject.sv
module prbs_err_inject #(
   parameter int WORD_W  = 32,
   parameter int SPACE_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv,
   input  logic               single_req,
   input  logic               per_en,
   input  logic [SPACE_W-1:0] spacing,
   output logic [WORD_W-1:0]  err_mask,
   output logic [SPACE_W-1:0] cnt
);

   logic               req_q;
   logic               pend_q;
   logic               pend_now;
   logic               per_on;
   logic [SPACE_W-1:0] cnt_q;
   logic [SPACE_W-1:0] cnt_nx;

   assign pend_now = pend_q | (single_req & ~req_q);
   assign per_on   = per_en && (spacing != '0);
   assign cnt      = cnt_q;

   always_comb begin
      logic [SPACE_W-1:0] c;
      logic [SPACE_W-1:0] lim;
      c        = cnt_q;
      lim      = spacing - 1'b1;
      err_mask = '0;
      if (per_on) begin
         for (int i = 0; i < WORD_W; i++) begin
            if (c >= lim) begin
               err_mask[WORD_W-1-i] = 1'b1;
               c                    = '0;
            end else begin
               c = c + 1'b1;
            end
         end
      end
      if (pend_now) err_mask[WORD_W-1] = 1'b1;
      cnt_nx = c;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         req_q  <= single_req;
         pend_q <= pend_now & ~adv;
         if (!per_on)  cnt_q <= '0;
         else if (adv) cnt_q <= cnt_nx;
      end
   end

endmodule

// File: rtl/prbs_out_stage.sv
module prbs_out_stage #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              invert_en,
   input  logic [WORD_W-1:0] word,
   input  logic [WORD_W-1:0] err_mask,
   output logic [WORD_W-1:0] data_out,
   output logic              data_valid
);

   logic [WORD_W-1:0] shaped;

   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      assign shaped[b] = word[b] ^ err_mask[b] ^ invert_en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_out   <= '0;
         data_valid <= 1'b0;
      end else begin
         data_valid <= adv;
         if (adv) data_out <= shaped;
      end
   end

endmodule

// File: rtl/prbs_pattern_src.sv
module prbs_pattern_src
   import prbs_gen_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int SPACE_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [4:0]         order_sel,
   input  logic               invert_en,
   input  logic               err_single,
   input  logic               err_periodic_en,
   input  logic [SPACE_W-1:0] err_spacing,
   output logic [WORD_W-1:0]  data_out,
   output logic               data_valid
);

   if (WORD_W < 1) begin : g_bad_word
      $error("prbs_pattern_src: WORD_W must be at least 1");
   end
   if (SPACE_W < 1 || SPACE_W > 31) begin : g_bad_space
      $error("prbs_pattern_src: SPACE_W must be 1..31");
   end

   logic [PRBS_ORD_W-1:0] ord_eff;
   logic [WORD_W-1:0]     raw_word;
   logic [WORD_W-1:0]     err_mask;
   logic                  core_adv;
   prbs_state_t           lfsr_state;
   logic [SPACE_W-1:0]    per_cnt;

   assign ord_eff = (order_sel < PRBS_ORD_W'(PRBS_MIN_ORD)) ? PRBS_ORD_W'(PRBS_MIN_ORD) : order_sel;

   prbs_lfsr_core #(.WORD_W(WORD_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .ord_eff (ord_eff),
      .word    (raw_word),
      .adv     (core_adv),
      .state   (lfsr_state)
   );

   prbs_err_inject #(.WORD_W(WORD_W), .SPACE_W(SPACE_W)) u_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (core_adv),
      .single_req (err_single),
      .per_en     (err_periodic_en),
      .spacing    (err_spacing),
      .err_mask   (err_mask),
      .cnt        (per_cnt)
   );

   prbs_out_stage #(.WORD_W(WORD_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (core_adv),
      .invert_en  (invert_en),
      .word       (raw_word),
      .err_mask   (err_mask),
      .data_out   (data_out),
      .data_valid (data_valid)
   );

endmodule

// File: rtl/prbs_gen_chk.sv
module prbs_gen_chk #(
   parameter int WORD_W  = 32,
   parameter int SPACE_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               core_adv,
   input logic               data_valid,
   input logic [WORD_W-1:0]  data_out,
   input logic [30:0]        lfsr_state,
   input logic               err_periodic_en,
   input logic [SPACE_W-1:0] err_spacing,
   input logic [SPACE_W-1:0] per_cnt
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!data_valid && data_out == '0));

   assert_state_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_state != '0);

   assert_reseed_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !core_adv |=> !data_valid);

   assert_steady_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      core_adv |=> data_valid);

   assert_cnt_below_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (core_adv && err_periodic_en && err_spacing != '0) |=> (per_cnt < $past(err_spacing)));

   assert_cnt_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_periodic_en || err_spacing == '0) |=> (per_cnt == '0));

endmodule

bind prbs_pattern_src prbs_gen_chk #(.WORD_W(WORD_W), .SPACE_W(SPACE_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .core_adv        (core_adv),
   .data_valid      (data_valid),
   .data_out        (data_out),
   .lfsr_state      (lfsr_state),
   .err_periodic_en (err_periodic_en),
   .err_spacing     (err_spacing),
   .per_cnt         (per_cnt)
);

// File: tb/prbs_pattern_src_tb_top.sv
`timescale 1ns/1ps
module prbs_pattern_src_tb_top;

   localparam int W  = 32;
   localparam int SW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [4:0]    order_sel;
   logic          invert_en;
   logic          err_single;
   logic          err_periodic_en;
   logic [SW-1:0] err_spacing;
   logic [W-1:0]  data_out;
   logic          data_valid;

   always #4 clk = ~clk;

   prbs_pattern_src #(.WORD_W(W), .SPACE_W(SW)) dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .order_sel       (order_sel),
      .invert_en       (invert_en),
      .err_single      (err_single),
      .err_periodic_en (err_periodic_en),
      .err_spacing     (err_spacing),
      .data_out        (data_out),
      .data_valid      (data_valid)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done   = 0;
   string cur_req = "R1";

   // behavioural model state
   bit       hist[$];
   int       m_ord;
   bit       m_prev_req;
   bit       m_pend;
   int       m_cnt;
   bit [W-1:0] exp_data;
   bit       exp_valid;

   function automatic bit has_exp(int ord, int k);
      int e[4];
      e = '{0, 0, 0, 0};
      case (ord)
         3: e = '{3,2,0,0};     4: e = '{4,3,0,0};     5: e = '{5,3,0,0};
         6: e = '{6,5,0,0};     7: e = '{7,6,0,0};     8: e = '{8,6,5,4};
         9: e = '{9,5,0,0};     10: e = '{10,7,0,0};   11: e = '{11,9,0,0};
         12: e = '{12,6,4,1};   13: e = '{13,4,3,1};   14: e = '{14,5,3,1};
         15: e = '{15,14,0,0};  16: e = '{16,15,13,4}; 17: e = '{17,14,0,0};
         18: e = '{18,11,0,0};  19: e = '{19,6,2,1};   20: e = '{20,17,0,0};
         21: e = '{21,19,0,0};  22: e = '{22,21,0,0};  23: e = '{23,18,0,0};
         24: e = '{24,23,22,17}; 25: e = '{25,22,0,0}; 26: e = '{26,6,2,1};
         27: e = '{27,5,2,1};   28: e = '{28,25,0,0};  29: e = '{29,27,0,0};
         30: e = '{30,6,4,1};   default: e = '{31,28,0,0};
      endcase
      foreach (e[j]) if (e[j] == k) return 1'b1;
      return 1'b0;
   endfunction

   task automatic seed_hist();
      hist.delete();
      for (int i = 0; i < 31; i++) hist.push_back(1'b1);
   endtask

   task automatic model_step();
      int      eff;
      bit      rise, pend_now, b;
      bit [W-1:0] word, mask;
      if (!rst_n) begin
         seed_hist();
         m_ord = 31; m_prev_req = 0; m_pend = 0; m_cnt = 0;
         exp_data = '0; exp_valid = 0;
         return;
      end
      eff        = (order_sel < 3) ? 3 : int'(order_sel);
      rise       = err_single && !m_prev_req;
      m_prev_req = err_single;
      pend_now   = m_pend || rise;
      if (!err_periodic_en || err_spacing == 0) m_cnt = 0;
      if (eff != m_ord) begin
         m_ord     = eff;
         seed_hist();
         exp_valid = 0;
         m_pend    = pend_now;
         return;
      end
      mask = '0;
      for (int i = 0; i < W; i++) begin
         b = 0;
         for (int k = 1; k <= 31; k++) if (has_exp(m_ord, k)) b ^= hist[k-1];
         hist.push_front(b);
         void'(hist.pop_back());
         word[W-1-i] = b;
         if (err_periodic_en && err_spacing != 0) begin
            if (m_cnt >= int'(err_spacing) - 1) begin
               mask[W-1-i] = 1'b1;
               m_cnt = 0;
            end else m_cnt++;
         end
      end
      if (pend_now) mask[W-1] = 1'b1;
      m_pend    = 0;
      exp_data  = word ^ mask ^ {W{invert_en}};
      exp_valid = 1;
   endtask

   task automatic check(bit ok, string what, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) begin
         model_step();
         @(posedge clk);
         @(negedge clk);
         check(data_valid === exp_valid, "data_valid", W'(data_valid), W'(exp_valid));
         check(data_out === exp_data, "data_out", data_out, exp_data);
      end
   endtask

   initial begin
      rst_n = 0; order_sel = 5'd7; invert_en = 0; err_single = 0;
      err_periodic_en = 0; err_spacing = '0;
      @(negedge clk);
      cur_req = "R1"; step(3);
      rst_n = 1;
      cur_req = "R1"; step(1);   // first clock after reset: reseed to order 7, still quiet
      // R1: explicit reset-state check
      check(data_valid === 1'b0 && data_out === '0, "post-reset state R1", data_out, '0);

      cur_req = "R2"; step(12);
      cur_req = "R3"; order_sel = 5'd31; step(1);
      check(data_valid === 1'b0, "reseed gap R3", W'(data_valid), '0);
      step(5);
      cur_req = "R4"; order_sel = 5'd0; step(4);
      order_sel = 5'd2; step(2);
      check(data_valid === 1'b1, "clamp no reseed R4", W'(data_valid), W'(1));
      order_sel = 5'd3; step(3);
      cur_req = "R2";
      for (int o = 4; o <= 31; o++) begin
         order_sel = 5'(o); step(3);
      end
      order_sel = 5'd15;
      step(3);

      cur_req = "R5"; err_single = 1; step(5);
      err_single = 0; step(2);
      err_single = 1; step(1); err_single = 0; step(2);

      cur_req = "R6"; order_sel = 5'd23; err_single = 1; step(1);
      err_single = 0; step(3);

      cur_req = "R7"; err_periodic_en = 1; err_spacing = 16'd5; step(6);
      err_spacing = 16'd32; step(4);
      err_spacing = 16'd33; step(5);
      err_spacing = 16'd45; step(5);
      err_spacing = 16'd1; step(2);
      err_spacing = 16'd3; step(3);

      cur_req = "R8"; err_spacing = 16'd0; step(4);
      err_spacing = 16'd7; step(2);
      err_periodic_en = 0; step(2);
      err_periodic_en = 1; step(3);

      cur_req = "R9"; err_spacing = 16'd1; err_single = 1; step(2);
      err_single = 0; err_spacing = 16'd32; step(1);
      err_single = 1; step(3); err_single = 0;

      cur_req = "R10"; err_periodic_en = 0; invert_en = 1; step(4);
      err_periodic_en = 1; err_spacing = 16'd9; err_single = 1; step(4);
      err_single = 0; order_sel = 5'd9; step(4);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL %s watchdog actual=hung expected=complete", cur_req);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule